// File: doc/BRIEF.md
# Byte-Lane Asynchronous Bus Cycle Master

This block turns single read or write requests into handshaked cycles on a 16-bit data bus that is addressed in words. A request carries a byte address, an access size (byte or word), a 3-bit cycle-type code and, for writes, the data. The block puts the word address on the bus and, one clock later, lowers the address strobe and the byte-lane strobes that the size and the low address bit select. It then waits for as long as it takes for the slave to lower its acknowledge.

When the acknowledge arrives, read data is captured and returned right-justified, or the write data is released. The cycle then closes with a one-clock response pulse. A low bus-error input ends the cycle with an error response instead. A low halt input lets a running cycle finish but keeps new cycles from starting. A word request at an odd address is answered with an alignment error and causes no bus activity.

Top module: `lane_bus_master`

## Requirements
- R1: The bus address output carries request address bits 23..1; bit 0 never leaves the block. The address is held from the address phase through the end of the cycle and until the next cycle is accepted.
- R2: While the address strobe is low, the upper strobe (low = bits 15..8) and the lower strobe (low = bits 7..0) follow the access. A word access lowers both. A byte access at an even address lowers only the upper strobe, and at an odd address only the lower strobe. Both strobes are never high while the address strobe is low.
- R3: The read/write line is high for a read and low for a write, stays constant for the whole cycle, and rests high between cycles.
- R4: An accepted cycle spends exactly one clock in an address phase, with the address valid and all strobes high, before the address strobe falls.
- R5: The cycle lasts until the acknowledge is sampled low, however many clocks that takes. One clock after that sample, rsp_valid pulses for one clock and all strobes are high again.
- R6: On a read, a word access returns the full bus data. A byte access returns the selected lane zero-extended in bits 7..0. Writes return zero.
- R7: The cycle-type output takes the request's code at the address phase and keeps it until the next accepted cycle, including the idle time between cycles.
- R8: A bus-error input sampled low during the strobe phase ends the cycle with rsp_err=1 and zero data. If acknowledge and bus error are low in the same clock, the error wins.
- R9: While halt is low, no new cycle starts and req_ready is low. A cycle already running completes normally.
- R10: A word request with address bit 0 set is answered one clock later with rsp_align=1. The address strobe stays high, and the address and type outputs keep their previous values.
- R11: A new cycle cannot be accepted while acknowledge or bus error is still low. After a cycle ends, the address strobe stays high for at least one clock.
- R12: For writes, bus_doe is high and bus_dout valid from the address phase until the acknowledge. Word writes drive the full word, and byte writes drive request data bits 7..0 on both lanes. bus_doe is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 24 | Byte address |
| req_kind | input | 3 | Cycle-type code |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Cycle ended by bus error |
| rsp_align | output | 1 | Request rejected as misaligned |
| rsp_rdata | output | 16 | Read data, byte reads right-justified |
| bus_addr | output | 23 | Word address (byte address bits 23..1) |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw | output | 1 | High read, low write |
| bus_uds_n | output | 1 | Upper lane strobe, active low |
| bus_lds_n | output | 1 | Lower lane strobe, active low |
| bus_kind | output | 3 | Cycle-type code |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low |
| bus_berr_n | input | 1 | Bus error, active low |
| bus_halt_n | input | 1 | Halt request, active low |

## Verification
Acknowledge and bus error can both be sampled low in the same strobe-phase clock. The bench provokes this by lowering both at one falling edge in the middle of a read whose bus data is non-zero. It then judges the response one clock later: rsp_err must be set and the data must be zero, so the error has priority. A second overlap is halt falling while a cycle is in its strobe phase. That cycle must still complete, and a pending request must stay unaccepted until halt is released.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int LBM_AW = 24;
  localparam int LBM_DW = 16;
  localparam int LBM_TW = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2
  } lbm_state_e;
endpackage

// File: rtl/lbm_lane_steer.sv
module lbm_lane_steer #(
  parameter int DW = 16
) (
  input  logic          word,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  output logic          up_en,
  output logic          lo_en,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] rj_data,
  output logic          misaligned
);
  localparam int HW = DW / 2;

  // {upper, lower} lane enables for an access
  function automatic logic [1:0] lane_mask(input logic w, input logic lsb);
    if (w) return 2'b11;
    return lsb ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [DW-1:0] right_justify(input logic [DW-1:0] d,
                                                  input logic w, input logic lsb);
    logic [DW-1:0] r;
    r = '0;
    if (w)        r = d;
    else if (lsb) r[HW-1:0] = d[HW-1:0];
    else          r[HW-1:0] = d[DW-1:HW];
    return r;
  endfunction

  function automatic logic [DW-1:0] place_write(input logic [DW-1:0] d, input logic w);
    return w ? d : {d[HW-1:0], d[HW-1:0]};
  endfunction

  logic [1:0] mask;
  assign mask       = lane_mask(word, a0);
  assign up_en      = mask[1];
  assign lo_en      = mask[0];
  assign dout       = place_write(wdata, word);
  assign rj_data    = right_justify(din, word, a0);
  assign misaligned = word & a0;
endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_bad,
  input  logic halt_n,
  input  logic ack_n,
  input  logic berr_n,
  output logic req_ready,
  output logic start_go,
  output logic reject_go,
  output logic end_ok,
  output logic end_err,
  output logic in_addr,
  output logic in_strb
);
  lbm_state_e state_q, state_d;
  logic fire;

  assign in_addr   = (state_q == ST_ADDR);
  assign in_strb   = (state_q == ST_STRB);
  assign req_ready = (state_q == ST_IDLE) && halt_n && ack_n && berr_n;
  assign fire      = req_valid && req_ready;
  assign start_go  = fire && !req_bad;
  assign reject_go = fire && req_bad;
  assign end_err   = in_strb && !berr_n;
  assign end_ok    = in_strb && berr_n && !ack_n;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_go) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: if (end_ok || end_err) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R4: strobe phase is always entered from the address phase
  p_strb_after_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && !$past(in_strb)) |-> $past(in_addr));

  // R9: halt observed in idle keeps the bus from leaving idle
  p_halt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !halt_n) |=> !in_addr);

  // R5: the strobe phase persists while neither acknowledge nor error is seen
  p_wait_unbounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strb && ack_n && berr_n) |=> in_strb);
endmodule

// File: rtl/lane_bus_master.sv
module lane_bus_master
  import lbm_pkg::*;
#(
  parameter int AW = LBM_AW,
  parameter int DW = LBM_DW,
  parameter int TW = LBM_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic          rsp_align,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:1] bus_addr,
  output logic          bus_as_n,
  output logic          bus_rw,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  output logic [TW-1:0] bus_kind,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ack_n,
  input  logic          bus_berr_n,
  input  logic          bus_halt_n
);
  // sequencer events, named for the assertions
  logic start_go, reject_go, end_ok, end_err, in_addr, in_strb, active;
  logic req_bad;

  // held request
  logic [AW-1:1] addr_q;
  logic          a0_q, wr_q, word_q;
  logic [TW-1:0] kind_q;
  logic [DW-1:0] wdata_q;

  logic          up_en, lo_en;
  logic [DW-1:0] dout_w, rj_w;
  logic          unused_up, unused_lo, unused_dout, cyc_bad;
  logic [DW-1:0] unused_rj, unused_d;

  // request-side alignment check
  lbm_lane_steer #(.DW(DW)) u_req_chk (
    .word(req_word), .a0(req_addr[0]), .wdata(req_wdata), .din(bus_din),
    .up_en(unused_up), .lo_en(unused_lo), .dout(unused_d), .rj_data(unused_rj),
    .misaligned(req_bad)
  );
  assign unused_dout = ^{unused_up, unused_lo, unused_d, unused_rj};

  // lane steering for the cycle in flight
  lbm_lane_steer #(.DW(DW)) u_cyc_steer (
    .word(word_q), .a0(a0_q), .wdata(wdata_q), .din(bus_din),
    .up_en(up_en), .lo_en(lo_en), .dout(dout_w), .rj_data(rj_w),
    .misaligned(cyc_bad)
  );

  lbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bad(req_bad),
    .halt_n(bus_halt_n), .ack_n(bus_ack_n), .berr_n(bus_berr_n),
    .req_ready(req_ready), .start_go(start_go), .reject_go(reject_go),
    .end_ok(end_ok), .end_err(end_err), .in_addr(in_addr), .in_strb(in_strb)
  );

  assign active = in_addr | in_strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      a0_q    <= 1'b0;
      wr_q    <= 1'b0;
      word_q  <= 1'b1;
      kind_q  <= '0;
      wdata_q <= '0;
    end else if (start_go) begin
      addr_q  <= req_addr[AW-1:1];
      a0_q    <= req_addr[0];
      wr_q    <= req_write;
      word_q  <= req_word;
      kind_q  <= req_kind;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_align <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= end_ok | end_err | reject_go;
      rsp_err   <= end_err;
      rsp_align <= reject_go;
      rsp_rdata <= (end_ok && !wr_q) ? rj_w : '0;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_kind  = kind_q;
  assign bus_as_n  = ~in_strb;
  assign bus_uds_n = ~(in_strb & up_en);
  assign bus_lds_n = ~(in_strb & lo_en);
  assign bus_rw    = ~(active & wr_q);
  assign bus_doe   = active & wr_q;
  assign bus_dout  = bus_doe ? dout_w : '0;

  // R2: a real access never leaves both lanes unselected
  p_lane_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !(bus_uds_n && bus_lds_n));

  // R2: a cycle in flight is never misaligned
  p_no_bad_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !cyc_bad);

  // R4: address already stable when the strobe falls
  p_addr_before_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> $stable(bus_addr));

  // R1/R3/R7: address, direction and type hold through the strobe phase
  p_hold_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !$past(bus_as_n)) |-> ($stable(bus_kind) && $stable(bus_addr) && $stable(bus_rw)));

  // R5: acknowledge closes the cycle with a response pulse
  p_ack_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !bus_ack_n) |=> (rsp_valid && bus_as_n));

  // R8: bus error wins and carries no data
  p_err_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !bus_berr_n) |=> (rsp_err && rsp_rdata == '0));

  // R10: misaligned request gives an alignment response and no bus activity
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject_go |=> (rsp_align && bus_as_n && $stable(bus_addr) && $stable(bus_kind)));

  // R11: strobe gap of at least one clock between cycles
  p_strobe_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |=> bus_as_n);

  // R12: write data is driven for the whole strobe phase of a write
  p_write_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && !bus_rw) |-> bus_doe);

  // R6: response flags are exclusive
  p_rsp_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_err && rsp_align));

  logic unused_ok;
  assign unused_ok = unused_dout;
endmodule

// File: tb/lane_bus_master_tb_top.sv
module lane_bus_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_word = 0;
  logic [23:0] req_addr = '0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, rsp_align;
  logic [15:0] rsp_rdata;
  logic [23:1] bus_addr;
  logic        bus_as_n, bus_rw, bus_uds_n, bus_lds_n, bus_doe;
  logic [2:0]  bus_kind;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_ack_n = 1, bus_berr_n = 1, bus_halt_n = 1;

  lane_bus_master dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic        word;
    logic [23:0] addr;
    logic [2:0]  kind;
    logic [15:0] wdata;
    logic [15:0] din;
    logic [7:0]  waits;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 24'h002344, 3'd5, 16'h0000, 16'hA1B2, 8'd0},
    '{1'b0, 1'b0, 24'h002344, 3'd1, 16'h0000, 16'hC3D4, 8'd2},
    '{1'b0, 1'b0, 24'h00ABC7, 3'd2, 16'h0000, 16'hE5F6, 8'd1},
    '{1'b1, 1'b1, 24'hFFFFFE, 3'd6, 16'h1234, 16'h0000, 8'd3},
    '{1'b1, 1'b0, 24'h100000, 3'd1, 16'h5A77, 16'h0000, 8'd0},
    '{1'b1, 1'b0, 24'h100001, 3'd2, 16'h00C9, 16'hFFFF, 8'd5},
    '{1'b0, 1'b1, 24'h7FFFF0, 3'd7, 16'h0000, 16'h8001, 8'd9},
    '{1'b0, 1'b0, 24'hFFFFFF, 3'd3, 16'h0000, 16'h9ABC, 8'd0}
  };

  // expected {uds_n, lds_n} while strobing
  function automatic logic [1:0] exp_strobes(input logic w, input logic a0);
    if (w) return 2'b00;
    if (a0) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [15:0] exp_read(input vec_t v);
    if (v.wr) return 16'h0000;
    if (v.word) return v.din;
    if (v.addr[0]) return {8'h00, v.din[7:0]};
    return {8'h00, v.din[15:8]};
  endfunction

  function automatic logic [15:0] exp_wdata(input vec_t v);
    return v.word ? v.wdata : {v.wdata[7:0], v.wdata[7:0]};
  endfunction

  // mode: 0 = ack, 1 = bus error, 2 = ack and error together, 3 = ack with halt lowered mid-cycle
  task automatic run_cycle(input vec_t v, input int mode);
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_word = v.word;
    req_addr = v.addr; req_kind = v.kind; req_wdata = v.wdata;
    chk("R11 ready before start", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    // address phase
    chk("R4 strobe high in address phase", bus_as_n, 1);
    chk("R1 word address", bus_addr, v.addr[23:1]);
    chk("R7 type at address phase", bus_kind, v.kind);
    chk("R3 direction", bus_rw, !v.wr);
    chk("R12 drive enable", bus_doe, v.wr);
    @(negedge clk);
    chk("R4 strobe low after one clock", bus_as_n, 0);
    chk("R2 lane strobes", {bus_uds_n, bus_lds_n}, exp_strobes(v.word, v.addr[0]));
    if (v.wr) chk("R12 write data", bus_dout, exp_wdata(v));
    if (mode == 3) bus_halt_n = 0;
    for (int i = 0; i < v.waits; i++) begin
      @(negedge clk);
      chk("R5 waits for acknowledge", {bus_as_n, rsp_valid}, 2'b00);
    end
    bus_din = v.din;
    if (mode != 1) bus_ack_n = 0;
    if (mode == 1 || mode == 2) bus_berr_n = 0;
    @(negedge clk);
    bus_ack_n = 1; bus_berr_n = 1; bus_din = 16'hDEAD;
    chk("R5 response pulse", rsp_valid, 1);
    chk("R5 strobes released", {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
    chk("R12 drive released", bus_doe, 0);
    if (mode == 0 || mode == 3) begin
      chk("R6 returned data", rsp_rdata, exp_read(v));
      chk("R8 no error", rsp_err, 0);
    end else begin
      chk("R8 error flagged", rsp_err, 1);
      chk("R8 no data on error", rsp_rdata, 0);
    end
    @(negedge clk);
    chk("R5 single pulse", rsp_valid, 0);
    chk("R11 gap after cycle", bus_as_n, 1);
    chk("R7 type held between cycles", bus_kind, v.kind);
    chk("R1 address held between cycles", bus_addr, v.addr[23:1]);
    chk("R3 rests high", bus_rw, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R5 reset rsp_valid", rsp_valid, 0);
    chk("R2 reset strobes", {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
    chk("R3 reset direction", bus_rw, 1);
    chk("R12 reset drive", bus_doe, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ready after reset", req_ready, 1);

    for (int k = 0; k < NV; k++) run_cycle(VECS[k], 0);

    // R10: odd word request is rejected without bus activity
    @(negedge clk);
    req_valid = 1; req_word = 1; req_write = 0; req_addr = 24'h000123; req_kind = 3'd4;
    @(negedge clk);
    req_valid = 0;
    chk("R10 alignment response", {rsp_valid, rsp_align, rsp_err}, 3'b110);
    chk("R10 no strobe", bus_as_n, 1);
    chk("R10 address unchanged", bus_addr, VECS[NV-1].addr[23:1]);
    chk("R10 type unchanged", bus_kind, VECS[NV-1].kind);
    @(negedge clk);
    chk("R10 still quiet", {bus_as_n, rsp_valid}, 2'b10);

    // R8: plain bus error, then error and acknowledge together
    run_cycle(VECS[0], 1);
    v = VECS[1]; v.din = 16'hFFFF;
    run_cycle(v, 2);

    // R9: halt blocks a pending request
    @(negedge clk);
    bus_halt_n = 0;
    req_valid = 1; req_word = 1; req_write = 0; req_addr = 24'h000200; req_kind = 3'd2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 no cycle while halted", {bus_as_n, req_ready}, 2'b10);
    end
    req_valid = 0;
    bus_halt_n = 1;

    // R9: halt lowered mid-cycle lets the cycle finish, then blocks
    run_cycle(VECS[2], 3);
    req_valid = 1; req_word = 0; req_addr = 24'h000010;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 blocked after finishing", bus_as_n, 1);
    end
    req_valid = 0;
    bus_halt_n = 1;

    // R11: acknowledge still low keeps a new cycle from starting
    @(negedge clk);
    bus_ack_n = 0;
    req_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 stuck acknowledge blocks start", {bus_as_n, req_ready}, 2'b10);
    end
    req_valid = 0;
    bus_ack_n = 1;
    run_cycle(VECS[5], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule